// File: doc/BRIEF.md
# Speculative Line-Prefetch Outcome Unit

This block settles what happens to a single line-prefetch operation once its address has been looked up. Each cycle that `op_valid` is high it takes the effective address, the instruction form (faulting or non-faulting), an exception-deferral bit, an optional base-register post-increment, the size of the current register stack frame, the result of the implemented-address check, a translation fault flag and a 2-bit locality hint. One cycle later it reports at most one of two things: a prefetch request, or a fault. It may also report a base-register writeback alongside a prefetch request or on its own.

The two forms differ only in how address problems are treated. The faulting form reports them. The non-faulting form drops them quietly. The deferral bit is the way out when a handler chooses not to resolve a fault: it suppresses the prefetch and every fault tied to it, but the base update still happens. The check for an illegal base register belongs to the base-update path alone. It applies to both forms and wins over everything else. The cache hierarchy, translation and the fault handler sit outside the block.

Top module: `prefetch_ctl`

## Requirements
- R1: While `rst` is high, `pf_valid`, `wb_valid` and `flt_valid` are 0. Every result appears exactly one clock after the edge that samples `op_valid`=1 and lasts a single cycle. With `op_valid`=0 all three strobes stay 0.
- R2: Consider the faulting form (`op_faulting`=1) with `op_defer`=0, `addr_impl`=1 and `xlat_fault`=0, and with no illegal base (see R8). The block asserts `pf_valid` with `pf_addr` equal to `op_addr`. It raises no fault.
- R3: The faulting form with `op_defer`=0 and `addr_impl`=0 raises a fault with `flt_kind`=1 (unimplemented address). It issues no prefetch and no writeback, whatever the value of `xlat_fault`.
- R4: The faulting form with `op_defer`=0, `addr_impl`=1 and `xlat_fault`=1 raises a fault with `flt_kind`=2 (translation). It issues no prefetch and no writeback.
- R5: Every prefetch-related fault (`flt_kind` 1 or 2) carries `flt_cause`=4 and `flt_nonaccess`=1. An illegal-operation fault (`flt_kind`=0) carries `flt_cause`=0 and `flt_nonaccess`=0.
- R6: The non-faulting form (`op_faulting`=0) with `addr_impl`=0 or `xlat_fault`=1 raises no fault and issues no prefetch. It still writes back the base register if `op_postinc`=1. With a clean address it issues the prefetch exactly as in R2.
- R7: With `op_defer`=1, in either form, the block issues no prefetch and raises no prefetch-related fault, for any address status. It writes back the base register if `op_postinc`=1.
- R8: Take `op_postinc`=1. The base register is legal when it is in 1..STATIC_REGS-1, or when it is at least STATIC_REGS and below STATIC_REGS+`frame_size`. Any other base, register 0 included, raises a fault with `flt_kind`=0 in either form and for either `op_defer` value. In that case the block issues no prefetch and no writeback.
- R9: A writeback carries `wb_reg`=`op_base`. `wb_data` is `op_addr` plus `op_inc` sign-extended, modulo 2^ADDR_W. With `op_postinc`=0 there is no writeback, and the base register is not checked, even if it is 0.
- R10: `pf_hint` repeats `op_hint` unchanged. The encoding is 00 temporal at level 1, 01 non-temporal at level 1, 10 non-temporal at level 2, 11 non-temporal at all levels.
- R11: `pf_valid` and `flt_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_addr | input | ADDR_W | Effective address |
| op_faulting | input | 1 | 1 = faulting form, 0 = non-faulting form |
| op_defer | input | 1 | Exception deferral: skip prefetch and its faults |
| op_postinc | input | 1 | Base-register post-increment requested |
| op_base | input | REG_W | Base register index |
| op_inc | input | INC_W | Signed increment amount |
| op_hint | input | 2 | Locality hint |
| frame_size | input | REG_W | Registers in the current stack frame |
| addr_impl | input | 1 | 1 = address is implemented |
| xlat_fault | input | 1 | Translation reported a fault |
| pf_valid | output | 1 | Prefetch request strobe |
| pf_addr | output | ADDR_W | Prefetch address |
| pf_hint | output | 2 | Locality hint for the request |
| wb_valid | output | 1 | Base-register writeback strobe |
| wb_reg | output | REG_W | Writeback register index |
| wb_data | output | ADDR_W | Incremented address |
| flt_valid | output | 1 | Fault strobe |
| flt_kind | output | 2 | 0 illegal operation, 1 unimplemented address, 2 translation |
| flt_cause | output | 4 | Cause code |
| flt_nonaccess | output | 1 | Non-access flag |

## Verification
The assertions take for granted that the inputs are stable across each sampling edge and that `rst` is applied for at least one edge before the first operation, so every `$past` reference in them lands on a cycle after reset. They do not assume that `op_valid` is spaced out. They also do not assume that `addr_impl` and `xlat_fault` are mutually exclusive, since the design resolves that case itself. The stimulus drives every input at the falling edge, keeps `op_valid` low throughout reset, and mixes back-to-back operations with idle gaps. It also includes frame sizes of zero and of the full width, so the base-range comparison is exercised at both of its ends.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

  typedef enum logic [1:0] {
    FK_ILLEGAL = 2'd0,
    FK_UNIMPL  = 2'd1,
    FK_XLAT    = 2'd2
  } flt_kind_e;

  localparam logic [3:0] PF_CAUSE_CODE = 4'd4;
  localparam logic [3:0] ILL_CAUSE_CODE = 4'd0;

  typedef struct packed {
    logic      pf;
    logic      wb;
    logic      flt;
    flt_kind_e kind;
  } outcome_t;

endpackage

// File: rtl/pfx_base_check.sv
module pfx_base_check #(
  parameter int ADDR_W      = 64,
  parameter int REG_W       = 7,
  parameter int INC_W       = 9,
  parameter int STATIC_REGS = 32
) (
  input  logic [REG_W-1:0]  base,
  input  logic [REG_W-1:0]  frame_size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [INC_W-1:0]  inc,
  output logic              base_ok,
  output logic [ADDR_W-1:0] next_addr
);
  localparam int          CMP_W    = REG_W + 1;
  localparam logic [CMP_W-1:0] STATIC_L = CMP_W'(STATIC_REGS);

  logic [CMP_W-1:0]  base_x;
  logic [CMP_W-1:0]  frame_end;
  logic [ADDR_W-1:0] inc_x;
  logic              in_static;
  logic              in_frame;

  always_comb begin
    base_x    = {1'b0, base};
    frame_end = STATIC_L + {1'b0, frame_size};
    in_static = (base_x < STATIC_L);
    in_frame  = (base_x >= STATIC_L) && (base_x < frame_end);
    base_ok   = (base != '0) && (in_static || in_frame);
    inc_x     = {{(ADDR_W-INC_W){inc[INC_W-1]}}, inc};
    next_addr = addr + inc_x;
  end

endmodule

// File: rtl/pfx_outcome.sv
module pfx_outcome
  import pfx_pkg::*;
(
  input  logic     faulting,
  input  logic     defer,
  input  logic     postinc,
  input  logic     base_ok,
  input  logic     addr_impl,
  input  logic     xlat_fault,
  output outcome_t res
);
  logic addr_bad;

  always_comb begin
    addr_bad = !addr_impl || xlat_fault;
    res      = '{pf: 1'b0, wb: 1'b0, flt: 1'b0, kind: FK_ILLEGAL};
    if (postinc && !base_ok) begin
      res.flt  = 1'b1;
      res.kind = FK_ILLEGAL;
    end else if (defer) begin
      res.wb = postinc;
    end else if (addr_bad) begin
      if (faulting) begin
        res.flt  = 1'b1;
        res.kind = !addr_impl ? FK_UNIMPL : FK_XLAT;
      end else begin
        res.wb = postinc;
      end
    end else begin
      res.pf = 1'b1;
      res.wb = postinc;
    end
  end

endmodule

// File: rtl/pfx_out_reg.sv
module pfx_out_reg
  import pfx_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int REG_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  outcome_t          res,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] next_addr,
  input  logic [REG_W-1:0]  base,
  input  logic [1:0]        hint,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr,
  output logic [1:0]        pf_hint,
  output logic              wb_valid,
  output logic [REG_W-1:0]  wb_reg,
  output logic [ADDR_W-1:0] wb_data,
  output logic              flt_valid,
  output logic [1:0]        flt_kind,
  output logic [3:0]        flt_cause,
  output logic              flt_nonaccess
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pf_valid  <= 1'b0;
      wb_valid  <= 1'b0;
      flt_valid <= 1'b0;
    end else begin
      pf_valid  <= valid && res.pf;
      wb_valid  <= valid && res.wb;
      flt_valid <= valid && res.flt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pf_addr       <= '0;
      pf_hint       <= '0;
      wb_reg        <= '0;
      wb_data       <= '0;
      flt_kind      <= '0;
      flt_cause     <= '0;
      flt_nonaccess <= 1'b0;
    end else if (valid) begin
      pf_addr       <= addr;
      pf_hint       <= hint;
      wb_reg        <= base;
      wb_data       <= next_addr;
      flt_kind      <= res.kind;
      flt_cause     <= (res.kind == FK_ILLEGAL) ? ILL_CAUSE_CODE : PF_CAUSE_CODE;
      flt_nonaccess <= (res.kind != FK_ILLEGAL);
    end
  end

endmodule

// File: rtl/prefetch_ctl.sv
module prefetch_ctl
  import pfx_pkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int REG_W       = 7,
  parameter int INC_W       = 9,
  parameter int STATIC_REGS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              op_faulting,
  input  logic              op_defer,
  input  logic              op_postinc,
  input  logic [REG_W-1:0]  op_base,
  input  logic [INC_W-1:0]  op_inc,
  input  logic [1:0]        op_hint,
  input  logic [REG_W-1:0]  frame_size,
  input  logic              addr_impl,
  input  logic              xlat_fault,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr,
  output logic [1:0]        pf_hint,
  output logic              wb_valid,
  output logic [REG_W-1:0]  wb_reg,
  output logic [ADDR_W-1:0] wb_data,
  output logic              flt_valid,
  output logic [1:0]        flt_kind,
  output logic [3:0]        flt_cause,
  output logic              flt_nonaccess
);
  logic              base_ok;
  logic [ADDR_W-1:0] next_addr;
  outcome_t          res;

  pfx_base_check #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .INC_W(INC_W), .STATIC_REGS(STATIC_REGS)
  ) base_chk_i (
    .base(op_base), .frame_size(frame_size), .addr(op_addr), .inc(op_inc),
    .base_ok(base_ok), .next_addr(next_addr)
  );

  pfx_outcome outcome_i (
    .faulting(op_faulting), .defer(op_defer), .postinc(op_postinc),
    .base_ok(base_ok), .addr_impl(addr_impl), .xlat_fault(xlat_fault),
    .res(res)
  );

  pfx_out_reg #(.ADDR_W(ADDR_W), .REG_W(REG_W)) out_reg_i (
    .clk(clk), .rst(rst), .valid(op_valid), .res(res),
    .addr(op_addr), .next_addr(next_addr), .base(op_base), .hint(op_hint),
    .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_hint(pf_hint),
    .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data),
    .flt_valid(flt_valid), .flt_kind(flt_kind), .flt_cause(flt_cause),
    .flt_nonaccess(flt_nonaccess)
  );

endmodule

// File: rtl/pfx_checker.sv
module pfx_checker #(
  parameter int ADDR_W = 64,
  parameter int REG_W  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic              op_defer,
  input logic              op_postinc,
  input logic [1:0]        op_hint,
  input logic              pf_valid,
  input logic [1:0]        pf_hint,
  input logic              wb_valid,
  input logic              flt_valid,
  input logic [1:0]        flt_kind,
  input logic [3:0]        flt_cause,
  input logic              flt_nonaccess
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(pf_valid && flt_valid)); // R11

  AST_RESULT_NEEDS_OP: assert property (@(posedge clk) disable iff (rst)
    (pf_valid || wb_valid || flt_valid) |-> $past(op_valid)); // R1

  AST_ILLEGAL_BLOCKS_ALL: assert property (@(posedge clk) disable iff (rst)
    (flt_valid && flt_kind == 2'd0) |-> (!pf_valid && !wb_valid)); // R8

  AST_PF_FAULT_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (flt_valid && flt_kind != 2'd0) |-> (flt_nonaccess && flt_cause == 4'd4)); // R5

  AST_HINT_PASS: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> (pf_hint == $past(op_hint))); // R10

  AST_DEFER_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(op_valid && op_defer) |-> (!pf_valid && !(flt_valid && flt_kind != 2'd0))); // R7

  AST_NO_INC_NO_WB: assert property (@(posedge clk) disable iff (rst)
    $past(op_valid && !op_postinc) |-> (!wb_valid && !(flt_valid && flt_kind == 2'd0))); // R9

endmodule

bind prefetch_ctl pfx_checker #(.ADDR_W(ADDR_W), .REG_W(REG_W)) chk_i (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_defer(op_defer),
  .op_postinc(op_postinc), .op_hint(op_hint), .pf_valid(pf_valid),
  .pf_hint(pf_hint), .wb_valid(wb_valid), .flt_valid(flt_valid),
  .flt_kind(flt_kind), .flt_cause(flt_cause), .flt_nonaccess(flt_nonaccess)
);

// File: tb/prefetch_ctl_tb_top.sv
`timescale 1ns/1ps
module prefetch_ctl_tb_top;
  localparam int ADDR_W = 64;
  localparam int REG_W  = 7;
  localparam int INC_W  = 9;
  localparam int STATIC_REGS = 32;
  localparam int WATCHDOG_CYC = 200000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              op_valid = 1'b0;
  logic [ADDR_W-1:0] op_addr = '0;
  logic              op_faulting = 1'b0;
  logic              op_defer = 1'b0;
  logic              op_postinc = 1'b0;
  logic [REG_W-1:0]  op_base = '0;
  logic [INC_W-1:0]  op_inc = '0;
  logic [1:0]        op_hint = '0;
  logic [REG_W-1:0]  frame_size = '0;
  logic              addr_impl = 1'b1;
  logic              xlat_fault = 1'b0;
  logic              pf_valid, wb_valid, flt_valid, flt_nonaccess;
  logic [ADDR_W-1:0] pf_addr, wb_data;
  logic [1:0]        pf_hint, flt_kind;
  logic [REG_W-1:0]  wb_reg;
  logic [3:0]        flt_cause;

  always #2 clk = ~clk;

  prefetch_ctl #(.ADDR_W(ADDR_W), .REG_W(REG_W), .INC_W(INC_W), .STATIC_REGS(STATIC_REGS)) dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_addr(op_addr),
    .op_faulting(op_faulting), .op_defer(op_defer), .op_postinc(op_postinc),
    .op_base(op_base), .op_inc(op_inc), .op_hint(op_hint), .frame_size(frame_size),
    .addr_impl(addr_impl), .xlat_fault(xlat_fault),
    .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_hint(pf_hint),
    .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data),
    .flt_valid(flt_valid), .flt_kind(flt_kind), .flt_cause(flt_cause),
    .flt_nonaccess(flt_nonaccess)
  );

  typedef struct {
    string             tag;
    logic              pf;
    logic [ADDR_W-1:0] pfa;
    logic [1:0]        hint;
    logic              wb;
    logic [REG_W-1:0]  wreg;
    logic [ADDR_W-1:0] wdata;
    logic              flt;
    logic [1:0]        kind;
    logic [3:0]        cause;
    logic              na;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  task automatic check(input string tag, input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // Driver: apply one operation at the falling edge and push its expected result.
  task automatic drive(input string tag, input logic fm, input logic df, input logic pi,
                       input logic [REG_W-1:0] br, input logic [INC_W-1:0] inc,
                       input logic [1:0] h, input logic [REG_W-1:0] fs,
                       input logic impl, input logic xf, input logic [ADDR_W-1:0] a);
    exp_t e;
    logic legal;
    @(negedge clk);
    op_valid = 1'b1; op_faulting = fm; op_defer = df; op_postinc = pi; op_base = br;
    op_inc = inc; op_hint = h; frame_size = fs; addr_impl = impl; xlat_fault = xf; op_addr = a;
    legal = (br != 0) && ((int'(br) < STATIC_REGS) || (int'(br) < STATIC_REGS + int'(fs)));
    e.tag = tag; e.pf = 0; e.wb = 0; e.flt = 0; e.kind = 0; e.cause = 0; e.na = 0;
    e.pfa = a; e.hint = h; e.wreg = br;
    e.wdata = a + {{(ADDR_W-INC_W){inc[INC_W-1]}}, inc};
    if (pi && !legal) begin
      e.flt = 1; e.kind = 2'd0;                       // R8
    end else if (df) begin
      e.wb = pi;                                      // R7
    end else if (!impl || xf) begin
      if (fm) begin
        e.flt = 1; e.kind = !impl ? 2'd1 : 2'd2;      // R3 R4
        e.cause = 4'd4; e.na = 1;                     // R5
      end else e.wb = pi;                             // R6
    end else begin
      e.pf = 1; e.wb = pi;                            // R2
    end
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      op_valid = 1'b0;
    end
  endtask

  // Monitor: one cycle after a sampled operation, pop and compare.
  initial begin
    logic was;
    exp_t e;
    forever begin
      @(posedge clk);
      was = op_valid && !rst;
      #1;
      if (!rst) begin
        if (was && exp_q.size() > 0) begin
          e = exp_q.pop_front();
          check({e.tag, " pf_valid"}, ADDR_W'(pf_valid), ADDR_W'(e.pf));
          check({e.tag, " wb_valid"}, ADDR_W'(wb_valid), ADDR_W'(e.wb));
          check({e.tag, " flt_valid"}, ADDR_W'(flt_valid), ADDR_W'(e.flt));
          if (e.pf) begin
            check({e.tag, " pf_addr"}, pf_addr, e.pfa);
            check({e.tag, " R10 pf_hint"}, ADDR_W'(pf_hint), ADDR_W'(e.hint));
          end
          if (e.wb) begin
            check({e.tag, " R9 wb_reg"}, ADDR_W'(wb_reg), ADDR_W'(e.wreg));
            check({e.tag, " R9 wb_data"}, wb_data, e.wdata);
          end
          if (e.flt) begin
            check({e.tag, " flt_kind"}, ADDR_W'(flt_kind), ADDR_W'(e.kind));
            check({e.tag, " R5 flt_cause"}, ADDR_W'(flt_cause), ADDR_W'(e.cause));
            check({e.tag, " R5 flt_nonaccess"}, ADDR_W'(flt_nonaccess), ADDR_W'(e.na));
          end
        end else begin
          check("R1 idle strobes", ADDR_W'({pf_valid, wb_valid, flt_valid}), '0);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset strobes", ADDR_W'({pf_valid, wb_valid, flt_valid}), '0);
    @(negedge clk); rst = 1'b0;
    idle(2);
    // R2 / R10: clean faulting form, every hint, with and without post-increment
    for (int h = 0; h < 4; h++)
      drive("R2 clean", 1, 0, h[0], 7'd40, 9'd64, 2'(h), 7'd16, 1, 0, 64'h1000_0000 + 64'(h));
    idle(1);
    // R9: negative increment wraps
    drive("R9 wrap", 1, 0, 1, 7'd5, 9'h1C0, 2'd3, 7'd0, 1, 0, 64'h20);
    // R3 / R4 / R5
    drive("R3 unimpl", 1, 0, 1, 7'd3, 9'd8, 2'd1, 7'd0, 0, 0, 64'hFFFF_0000_0000_0000);
    drive("R3 unimpl+xlat", 1, 0, 0, 7'd0, 9'd8, 2'd2, 7'd0, 0, 1, 64'h44);
    drive("R4 xlat", 1, 0, 1, 7'd33, 9'd16, 2'd0, 7'd4, 1, 1, 64'h8000);
    idle(2);
    // R6: non-faulting form
    drive("R6 nf unimpl", 0, 0, 1, 7'd10, 9'd32, 2'd1, 7'd0, 0, 0, 64'h9000);
    drive("R6 nf xlat", 0, 0, 0, 7'd10, 9'd32, 2'd1, 7'd0, 1, 1, 64'h9000);
    drive("R6 nf clean", 0, 0, 1, 7'd12, 9'd1, 2'd2, 7'd0, 1, 0, 64'hABC0);
    // R7: deferral in both forms
    drive("R7 defer f unimpl", 1, 1, 1, 7'd2, 9'd4, 2'd3, 7'd0, 0, 1, 64'h500);
    drive("R7 defer f clean", 1, 1, 0, 7'd2, 9'd4, 2'd3, 7'd0, 1, 0, 64'h500);
    drive("R7 defer nf", 0, 1, 1, 7'd34, 9'd4, 2'd0, 7'd3, 1, 0, 64'h600);
    idle(1);
    // R8: illegal base register
    drive("R8 base0", 1, 0, 1, 7'd0, 9'd4, 2'd0, 7'd10, 1, 0, 64'h700);
    drive("R8 beyond frame", 0, 0, 1, 7'd42, 9'd4, 2'd0, 7'd10, 0, 0, 64'h700);
    drive("R8 at frame edge", 1, 1, 1, 7'd41, 9'd4, 2'd0, 7'd10, 1, 0, 64'h700);
    drive("R8 empty frame", 1, 0, 1, 7'd32, 9'd4, 2'd1, 7'd0, 1, 0, 64'h710);
    drive("R8 defer illegal", 1, 1, 1, 7'd0, 9'd4, 2'd1, 7'd5, 0, 1, 64'h720);
    drive("R8 full frame", 1, 0, 1, 7'd127, 9'd4, 2'd2, 7'd127, 1, 0, 64'h730);
    drive("R8 static top", 0, 0, 1, 7'd31, 9'd4, 2'd2, 7'd0, 1, 0, 64'h740);
    // R9: no post-increment, base 0 is fine
    drive("R9 no inc base0", 1, 0, 0, 7'd0, 9'd4, 2'd3, 7'd0, 1, 0, 64'h750);
    drive("R9 no inc fault", 1, 0, 0, 7'd0, 9'd4, 2'd3, 7'd0, 0, 0, 64'h760);
    idle(4);
    // R11 is exercised by every compare above: never both strobes.
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule